// File: doc/BRIEF.md
# CPU Bus Address Decoder with Region Mirroring

This block sits on the 16-bit address bus of an 8-bit console processor and turns each bus cycle into a single chip select and a folded local address. Six regions are recognised: the 2 KiB work RAM inside the console, the eight graphics-unit registers, the I/O and sound register block, the expansion window, cartridge work RAM and the cartridge program ROM. Accesses to mirrored windows are folded back onto the base copy, so the memory or register block behind a select only ever sees its own small offset.

The program ROM window is 32 KiB wide. A static configuration input says whether the cartridge carries one or two 16 KiB banks. With two banks, a bank output tells the ROM which half was addressed. With one bank, both halves of the window reach the same bank. This covers the reset vector at 0xFFFC/0xFFFD: it lands on the last bytes of the single bank.

All outputs are registered. The select vector, the local address, the ROM bank bit and the write strobe all appear together one clock after the bus address is presented.

Top module: `addr_bus_decoder`

## Requirements
- R1: A valid access in 0x0000–0x1FFF asserts chip_sel bit 0 (RAM), and local_addr equals the bus address ANDed with 0x07FF.
- R2: A valid access in 0x2000–0x3FFF asserts chip_sel bit 1 (graphics registers), and local_addr equals bus address bits [2:0] with all upper bits zero.
- R3: A valid access in 0x4000–0x401F asserts chip_sel bit 2 (I/O and sound), and local_addr equals bus address bits [4:0].
- R4: A valid access in 0x4020–0x5FFF asserts chip_sel bit 3 (expansion), and local_addr equals the bus address minus 0x4000 (bits [12:0]).
- R5: A valid access in 0x6000–0x7FFF asserts chip_sel bit 4 (cartridge work RAM), and local_addr equals the bus address minus 0x6000.
- R6: A valid access in 0x8000–0xFFFF asserts chip_sel bit 5 (program ROM), and local_addr equals bus address bits [13:0]. With rom_two_banks = 1, rom_bank equals bus address bit 14 (0 = lower bank at 0x8000, 1 = upper bank at 0xC000).
- R7: With rom_two_banks = 0, rom_bank stays 0 and both ROM halves give the same offset. For example, 0xFFFC and 0xBFFC both give local_addr 0x3FFC.
- R8: When bus_valid is low, chip_sel, local_addr, rom_bank and wr_out are all zero in the following cycle.
- R9: Outputs appear exactly one clock after the inputs are sampled. wr_out equals bus_valid AND bus_we from that same input cycle.
- R10: While rst is high, all outputs are zero on the following clock.
- R11: Each valid access asserts exactly one chip_sel bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus cycle is active this clock |
| bus_we | input | 1 | High for a write, low for a read |
| bus_addr | input | 16 | CPU bus address |
| rom_two_banks | input | 1 | 1: cartridge has two 16 KiB program banks; 0: one bank |
| chip_sel | output | 6 | One-hot select: bit 0 RAM, 1 graphics, 2 I/O, 3 expansion, 4 work RAM, 5 ROM |
| local_addr | output | 14 | Folded offset within the selected region |
| rom_bank | output | 1 | ROM half selected (two-bank case only) |
| wr_out | output | 1 | Write strobe aligned with the selects |

## Verification
The decoder is tried at every region edge: the first and last byte of each region, and the first byte past it. These accesses show whether each comparison boundary is off by one. Addresses high in the mirror windows (0x1FFF, 0x3FFF, 0x2008) show whether folding masks the right bits and not just the base copy. The ROM vectors and both ROM halves are accessed with the bank configuration set each way, which separates the mirrored case from the banked case. A long run of random addresses, strobes and idle cycles, compared with a behavioural model every clock, covers the idle gating and the write-strobe alignment.

// File: rtl/busdec_pkg.sv
package busdec_pkg;
  localparam int ADDR_W      = 16;
  localparam int LOCAL_W     = 14;
  localparam int NUM_REGIONS = 6;
  localparam int REGION_W    = $clog2(NUM_REGIONS);

  localparam int RAM_AW  = 11;
  localparam int GFX_AW  = 3;
  localparam int IO_AW   = 5;
  localparam int WIN_AW  = 13;
  localparam int BANK_AW = 14;

  localparam logic [ADDR_W-1:0] GFX_BASE  = 16'h2000;
  localparam logic [ADDR_W-1:0] IO_BASE   = 16'h4000;
  localparam logic [ADDR_W-1:0] EXP_BASE  = 16'h4020;
  localparam logic [ADDR_W-1:0] WRAM_BASE = 16'h6000;
  localparam logic [ADDR_W-1:0] ROM_BASE  = 16'h8000;

  typedef enum logic [REGION_W-1:0] {
    RG_RAM  = 3'd0,
    RG_GFX  = 3'd1,
    RG_IO   = 3'd2,
    RG_EXP  = 3'd3,
    RG_WRAM = 3'd4,
    RG_ROM  = 3'd5
  } region_e;
endpackage

// File: rtl/addr_region_classify.sv
module addr_region_classify
  import busdec_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);
  // Priority order from the top of the map down; each compare is a lower bound.
  always_comb begin
    if (addr >= ROM_BASE)       region = RG_ROM;
    else if (addr >= WRAM_BASE) region = RG_WRAM;
    else if (addr >= EXP_BASE)  region = RG_EXP;
    else if (addr >= IO_BASE)   region = RG_IO;
    else if (addr >= GFX_BASE)  region = RG_GFX;
    else                        region = RG_RAM;
  end
endmodule

// File: rtl/addr_local_fold.sv
module addr_local_fold
  import busdec_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int LW      = LOCAL_W,
  parameter int RAM_W   = RAM_AW,
  parameter int GFX_W   = GFX_AW,
  parameter int IO_W    = IO_AW,
  parameter int WIN_W   = WIN_AW,
  parameter int BANK_W  = BANK_AW
) (
  input  logic [AW-1:0] addr,
  input  region_e       region,
  input  logic          two_banks,
  output logic [LW-1:0] local_addr,
  output logic          bank_hi
);
  // Mirrors collapse by dropping high address bits; no subtraction is needed
  // because every base is aligned to its window size.
  always_comb begin
    local_addr = '0;
    bank_hi    = 1'b0;
    unique case (region)
      RG_RAM:  local_addr[RAM_W-1:0]  = addr[RAM_W-1:0];
      RG_GFX:  local_addr[GFX_W-1:0]  = addr[GFX_W-1:0];
      RG_IO:   local_addr[IO_W-1:0]   = addr[IO_W-1:0];
      RG_EXP:  local_addr[WIN_W-1:0]  = addr[WIN_W-1:0];
      RG_WRAM: local_addr[WIN_W-1:0]  = addr[WIN_W-1:0];
      RG_ROM: begin
        local_addr[BANK_W-1:0] = addr[BANK_W-1:0];
        bank_hi                = two_banks & addr[BANK_W];
      end
      default: local_addr = '0;
    endcase
  end
endmodule

// File: rtl/addr_bus_decoder.sv
module addr_bus_decoder
  import busdec_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int LW  = LOCAL_W,
  parameter int NR  = NUM_REGIONS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic          rom_two_banks,
  output logic [NR-1:0] chip_sel,
  output logic [LW-1:0] local_addr,
  output logic          rom_bank,
  output logic          wr_out
);
  region_e       region;
  logic [LW-1:0] fold_addr;
  logic          fold_bank;
  logic [NR-1:0] sel_d;

  addr_region_classify #(.AW(AW)) u_classify (
    .addr   (bus_addr),
    .region (region)
  );

  addr_local_fold #(.AW(AW), .LW(LW)) u_fold (
    .addr       (bus_addr),
    .region     (region),
    .two_banks  (rom_two_banks),
    .local_addr (fold_addr),
    .bank_hi    (fold_bank)
  );

  for (genvar g = 0; g < NR; g++) begin : g_sel
    assign sel_d[g] = bus_valid && (region == region_e'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_sel   <= '0;
      local_addr <= '0;
      rom_bank   <= 1'b0;
      wr_out     <= 1'b0;
    end else begin
      chip_sel   <= sel_d;
      local_addr <= bus_valid ? fold_addr : '0;
      rom_bank   <= bus_valid & fold_bank;
      wr_out     <= bus_valid & bus_we;
    end
  end
endmodule

// File: rtl/addr_bus_decoder_chk.sv
module addr_bus_decoder_chk #(
  parameter int AW = 16,
  parameter int LW = 14,
  parameter int NR = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_valid,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          rom_two_banks,
  input logic [NR-1:0] chip_sel,
  input logic [LW-1:0] local_addr,
  input logic          rom_bank,
  input logic          wr_out
);
  p_one_select_r11: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> $onehot(chip_sel));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (chip_sel == '0 && local_addr == '0 && !rom_bank && !wr_out));

  p_write_align_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we) |=> wr_out);

  p_read_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> !wr_out);

  p_ram_fold_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr < 16'h2000) |=> (chip_sel[0] && local_addr[LW-1:11] == '0));

  p_gfx_fold_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr >= 16'h2000 && bus_addr < 16'h4000)
      |=> (chip_sel[1] && local_addr[LW-1:3] == '0));

  p_single_bank_r7: assert property (@(posedge clk) disable iff (rst)
    !rom_two_banks |=> !rom_bank);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (chip_sel == '0 && !wr_out && !rom_bank));
endmodule

bind addr_bus_decoder addr_bus_decoder_chk #(.AW(AW), .LW(LW), .NR(NR)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_valid     (bus_valid),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .rom_two_banks (rom_two_banks),
  .chip_sel      (chip_sel),
  .local_addr    (local_addr),
  .rom_bank      (rom_bank),
  .wr_out        (wr_out)
);

// File: tb/sim_addr_bus_decoder.sv
module sim_addr_bus_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        rom_two_banks = 1'b1;
  logic [5:0]  chip_sel;
  logic [13:0] local_addr;
  logic        rom_bank;
  logic        wr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_bus_decoder u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .rom_two_banks(rom_two_banks),
    .chip_sel(chip_sel), .local_addr(local_addr),
    .rom_bank(rom_bank), .wr_out(wr_out)
  );

  typedef struct {
    int    cs;
    int    loc;
    int    bank;
    int    we;
    string req;
  } exp_t;

  exp_t pending[$];

  function automatic exp_t model(bit v, bit w, int a, bit tb);
    exp_t e;
    e.cs = 0; e.loc = 0; e.bank = 0; e.we = 0; e.req = "R8";
    if (v) begin
      e.we = w;
      if (a < 'h2000)      begin e.cs = 1;  e.loc = a % 2048;   e.req = "R1"; end
      else if (a < 'h4000) begin e.cs = 2;  e.loc = a % 8;      e.req = "R2"; end
      else if (a < 'h4020) begin e.cs = 4;  e.loc = a - 'h4000; e.req = "R3"; end
      else if (a < 'h6000) begin e.cs = 8;  e.loc = a - 'h4000; e.req = "R4"; end
      else if (a < 'h8000) begin e.cs = 16; e.loc = a - 'h6000; e.req = "R5"; end
      else begin
        e.cs  = 32;
        e.loc = (a - 'h8000) % 16384;
        e.bank = tb ? (a >= 'hC000) : 0;
        e.req = tb ? "R6" : "R7";
      end
    end
    return e;
  endfunction

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Drive at a falling edge, then compare at the next falling edge (R9 latency).
  task automatic step(bit v, bit w, int a, bit tb);
    exp_t e;
    bus_valid = v; bus_we = w; bus_addr = a[15:0]; rom_two_banks = tb;
    pending.push_back(model(v, w, a, tb));
    @(negedge clk);
    e = pending.pop_front();
    check(e.req, "chip_sel", int'(chip_sel), e.cs);
    check(e.req, "local_addr", int'(local_addr), e.loc);
    check(e.req, "rom_bank", int'(rom_bank), e.bank);
    check("R9", "wr_out", int'(wr_out), e.we);
    check("R11", "one_select", $countones(chip_sel), v ? 1 : 0);
  endtask

  initial begin
    int edges[$] = '{'h0000, 'h07FF, 'h0800, 'h1FFF, 'h2000, 'h2007, 'h2008,
                     'h3FFF, 'h4000, 'h401F, 'h4020, 'h5FFF, 'h6000, 'h7FFF,
                     'h8000, 'hBFFF, 'hC000, 'hFFFC, 'hFFFD, 'hFFFF};
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 16'h8000;
    repeat (3) @(negedge clk);
    check("R10", "chip_sel", int'(chip_sel), 0);
    check("R10", "wr_out", int'(wr_out), 0);
    check("R10", "local_addr", int'(local_addr), 0);
    rst = 1'b0;

    foreach (edges[i]) step(1'b1, i[0], edges[i], 1'b1);
    foreach (edges[i]) step(1'b1, ~i[0], edges[i], 1'b0);
    // R7: both halves of a single bank give the same offset
    step(1'b1, 1'b0, 'hBFFC, 1'b0);
    step(1'b1, 1'b0, 'hFFFC, 1'b0);
    step(1'b1, 1'b0, 'hFFFD, 1'b1);
    // R8: idle with a write strobe and a ROM address held on the bus
    step(1'b0, 1'b1, 'hFFFF, 1'b1);
    step(1'b0, 1'b0, 'h1234, 1'b0);
    for (int k = 0; k < 4000; k++) begin
      bit v  = ($urandom % 5) != 0;
      bit w  = $urandom % 2;
      bit tb = $urandom % 2;
      step(v, w, int'($urandom % 65536), tb);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule